// File: doc/BRIEF.md
# Atomic 128-bit Register-Pair Swap Unit

This unit executes one atomic 128-bit exchange instruction. It accepts a 32-bit instruction word with its execution context: the feature enable, the endian mode, the exception level, the overlap policy and the stack pointer. It decodes the word and reads two 64-bit data registers and the base register from three combinational register-file read ports. It joins the two data registers into a 128-bit store value and sends one swap request to memory. It then splits the 128-bit old value that memory returns and writes the halves back into the same two registers, using two write ports in a single cycle.

Some instructions end without touching memory or registers. The unit reports each of these as undefined, as a no-op or as an alignment fault. The report comes in the cycle that `done_o` pulses. A sequencer steps through a fixed order of states: decode, request, wait, writeback and done. `busy_o` is high for the whole operation.

Top module: `pair_swap_unit`

## Requirements
- R1: A word is recognised only when bits [31:24] are 0001_1001, bit 21 is 1 and bits [15:10] are 10_0000. Any other word ends as undefined. Field positions: first data index [4:0], base index [9:5], second data index [20:16], release flag bit 22, acquire flag bit 23.
- R2: With `feat_en_i` low at accept, the operation ends as undefined.
- R3: A first or second data index of 31 ends as undefined.
- R4: Equal data indices follow `ovl_mode_i`: 0 gives undefined, 1 gives a no-op with no memory request and no write, 2 performs the swap but writes the filler word 64'hA5A5_5A5A_A5A5_5A5A into the register, and 3 gives undefined.
- R5: A base index of 31 addresses memory with `sp_i`. Any other base index uses that register's value. `mem_tag_o` is 1 exactly when the base index is not 31.
- R6: With base index 31 and `sp_i[3:0]` not zero, the operation ends as an alignment fault with no memory request and no register write. Undefined and no-op outcomes take precedence over the alignment check.
- R7: The store value is {first, second} when `big_endian_i` is 1 and {second, first} when it is 0. Memory then holds that value.
- R8: In big-endian mode the first register receives the old upper 64 bits and the second register the lower 64 bits. In little-endian mode the order is reversed. Both writes happen in one cycle after the response.
- R9: The request carries acquire = bit 23, release = bit 22 and privileged = (`el_i` != 0). `mem_req_o` and its payload hold steady until `mem_ready_i` is high.
- R10: `busy_o` rises the cycle after accept and falls the cycle after the one-cycle `done_o` pulse. `start_i` is ignored while busy. At most one outcome flag is set, and only with `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Accept an instruction when idle |
| instr_i | input | 32 | Instruction word |
| feat_en_i | input | 1 | 128-bit atomic feature enabled |
| big_endian_i | input | 1 | Big-endian data access |
| el_i | input | 2 | Current exception level |
| ovl_mode_i | input | 2 | Policy for equal data indices |
| sp_i | input | 64 | Stack pointer |
| rf_raddr0_o | output | 5 | Read index, first data register |
| rf_raddr1_o | output | 5 | Read index, second data register |
| rf_raddr2_o | output | 5 | Read index, base register |
| rf_rdata0_i | input | 64 | First data register value |
| rf_rdata1_i | input | 64 | Second data register value |
| rf_rdata2_i | input | 64 | Base register value |
| rf_we_o | output | 1 | Write enable for both write ports |
| rf_waddr0_o | output | 5 | Write index, port 0 |
| rf_wdata0_o | output | 64 | Write data, port 0 |
| rf_waddr1_o | output | 5 | Write index, port 1 |
| rf_wdata1_o | output | 64 | Write data, port 1 |
| mem_req_o | output | 1 | Swap request valid |
| mem_ready_i | input | 1 | Request accepted |
| mem_addr_o | output | 64 | Request address |
| mem_wdata_o | output | 128 | Store value |
| mem_acq_o | output | 1 | Acquire semantics |
| mem_rel_o | output | 1 | Release semantics |
| mem_priv_o | output | 1 | Privileged access |
| mem_tag_o | output | 1 | Tag check requested |
| mem_rsp_valid_i | input | 1 | Response valid |
| mem_rdata_i | input | 128 | Old memory value |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Operation finished, one cycle |
| undef_o | output | 1 | Outcome: undefined |
| nop_o | output | 1 | Outcome: no-op |
| align_fault_o | output | 1 | Outcome: stack-pointer alignment fault |

## Verification
Several fault conditions can hold for the same instruction word, and all of them are resolved in the single decode cycle. Directed cases combine them on purpose: a misaligned stack pointer with the feature disabled, and a misaligned stack pointer with equal indices under the no-op policy. Random cases mix all the conditions freely. Each case is judged by the outcome flag, by the count of memory requests and register writes, and by unchanged register and memory contents. A second coincidence is the fill-mode writeback, where both write ports name the same register in the same cycle; the bench checks that the register ends with the filler word.

// File: rtl/pswap_pkg.sv
package pswap_pkg;
  localparam int XLEN   = 64;
  localparam int IDX_W  = 5;
  localparam int DATA_W = 2 * XLEN;

  localparam logic [7:0] OPC_TOP = 8'b0001_1001;
  localparam logic [5:0] OPC_FIX = 6'b10_0000;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DECODE, ST_REQ, ST_WAIT, ST_WB, ST_DONE
  } state_t;

  typedef enum logic [1:0] {
    RES_OK, RES_UNDEF, RES_NOP, RES_ALIGN
  } result_t;

  typedef enum logic [1:0] {
    OVL_UNDEF = 2'd0, OVL_NOP = 2'd1, OVL_FILL = 2'd2, OVL_RSVD = 2'd3
  } ovl_t;
endpackage

// File: rtl/pswap_decode.sv
module pswap_decode
  import pswap_pkg::*;
#(
  parameter int IW = IDX_W
) (
  input  logic [31:0]   instr_i,
  input  logic          feat_i,
  input  logic [1:0]    ovl_i,
  output logic [IW-1:0] rt_o,
  output logic [IW-1:0] rt2_o,
  output logic [IW-1:0] rn_o,
  output logic          acq_o,
  output logic          rel_o,
  output result_t       res_o,
  output logic          fill_o
);
  localparam logic [IW-1:0] IDX_MAX = '1;

  logic match;

  assign rt_o  = instr_i[4:0];
  assign rn_o  = instr_i[9:5];
  assign rt2_o = instr_i[20:16];
  assign rel_o = instr_i[22];
  assign acq_o = instr_i[23];

  assign match = (instr_i[31:24] == OPC_TOP) && instr_i[21] && (instr_i[15:10] == OPC_FIX);

  always_comb begin
    res_o  = RES_OK;
    fill_o = 1'b0;
    if (!feat_i || !match || rt_o == IDX_MAX || rt2_o == IDX_MAX) begin
      res_o = RES_UNDEF;
    end else if (rt_o == rt2_o) begin
      unique case (ovl_t'(ovl_i))
        OVL_NOP:  res_o  = RES_NOP;
        OVL_FILL: fill_o = 1'b1;
        default:  res_o  = RES_UNDEF;
      endcase
    end
  end
endmodule

// File: rtl/pswap_endian.sv
module pswap_endian #(
  parameter int W = 64
) (
  input  logic           big_i,
  input  logic [W-1:0]   v1_i,
  input  logic [W-1:0]   v2_i,
  output logic [2*W-1:0] store_o,
  input  logic [2*W-1:0] load_i,
  output logic [W-1:0]   r1_o,
  output logic [W-1:0]   r2_o
);
  logic [W-1:0] hi, lo;

  assign hi = load_i[2*W-1:W];
  assign lo = load_i[W-1:0];

  always_comb begin
    if (big_i) begin
      store_o = {v1_i, v2_i};
      r1_o    = hi;
      r2_o    = lo;
    end else begin
      store_o = {v2_i, v1_i};
      r1_o    = lo;
      r2_o    = hi;
    end
  end
endmodule

// File: rtl/pswap_ctrl.sv
module pswap_ctrl
  import pswap_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    start_i,
  input  result_t dec_res_i,
  input  logic    sp_bad_i,
  input  logic    mem_ready_i,
  input  logic    rsp_valid_i,
  output state_t  state_o,
  output result_t res_o,
  output logic    busy_o,
  output logic    done_o
);
  state_t  state_q, state_d;
  result_t res_q, res_d;

  // decode outcome wins over alignment
  always_comb begin
    res_d = res_q;
    if (state_q == ST_DECODE) begin
      if (dec_res_i != RES_OK) res_d = dec_res_i;
      else if (sp_bad_i)       res_d = RES_ALIGN;
      else                     res_d = RES_OK;
    end
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_i) state_d = ST_DECODE;
      ST_DECODE: state_d = (res_d == RES_OK) ? ST_REQ : ST_DONE;
      ST_REQ:    if (mem_ready_i) state_d = ST_WAIT;
      ST_WAIT:   if (rsp_valid_i) state_d = ST_WB;
      ST_WB:     state_d = ST_DONE;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      res_q   <= RES_OK;
    end else begin
      state_q <= state_d;
      res_q   <= res_d;
    end
  end

  assign state_o = state_q;
  assign res_o   = res_q;
  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = (state_q == ST_DONE);

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
  AST_REQ_WAITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_REQ && !mem_ready_i) |=> (state_q == ST_REQ)); // R9
  AST_FAULT_SKIPS_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DONE && res_q != RES_OK) |-> ($past(state_q) == ST_DECODE)); // R6
endmodule

// File: rtl/pair_swap_unit.sv
module pair_swap_unit
  import pswap_pkg::*;
#(
  parameter int          XW        = XLEN,
  parameter int          IW        = IDX_W,
  parameter int          SP_ALIGN  = 16,
  parameter logic [63:0] FILL_WORD = 64'hA5A5_5A5A_A5A5_5A5A
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [31:0]     instr_i,
  input  logic            feat_en_i,
  input  logic            big_endian_i,
  input  logic [1:0]      el_i,
  input  logic [1:0]      ovl_mode_i,
  input  logic [XW-1:0]   sp_i,
  output logic [IW-1:0]   rf_raddr0_o,
  output logic [IW-1:0]   rf_raddr1_o,
  output logic [IW-1:0]   rf_raddr2_o,
  input  logic [XW-1:0]   rf_rdata0_i,
  input  logic [XW-1:0]   rf_rdata1_i,
  input  logic [XW-1:0]   rf_rdata2_i,
  output logic            rf_we_o,
  output logic [IW-1:0]   rf_waddr0_o,
  output logic [XW-1:0]   rf_wdata0_o,
  output logic [IW-1:0]   rf_waddr1_o,
  output logic [XW-1:0]   rf_wdata1_o,
  output logic            mem_req_o,
  input  logic            mem_ready_i,
  output logic [XW-1:0]   mem_addr_o,
  output logic [2*XW-1:0] mem_wdata_o,
  output logic            mem_acq_o,
  output logic            mem_rel_o,
  output logic            mem_priv_o,
  output logic            mem_tag_o,
  input  logic            mem_rsp_valid_i,
  input  logic [2*XW-1:0] mem_rdata_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            undef_o,
  output logic            nop_o,
  output logic            align_fault_o
);
  localparam int            AL_W    = $clog2(SP_ALIGN);
  localparam logic [IW-1:0] IDX_SP  = '1;
  localparam int            DW      = 2 * XW;

  state_t  state;
  result_t dec_res, res;

  logic [31:0]   instr_q;
  logic          feat_q, big_q, priv_q;
  logic [1:0]    ovl_q;
  logic [XW-1:0] sp_q;
  logic [IW-1:0] rt, rt2, rn;
  logic          acq, rel, fill_d, fill_q;
  logic          sp_bad, accept;
  logic [XW-1:0] addr_q;
  logic [DW-1:0] store_d, store_q, load_q;
  logic [XW-1:0] wb1, wb2;

  assign accept = start_i && (state == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      instr_q <= '0;
      feat_q  <= 1'b0;
      big_q   <= 1'b0;
      priv_q  <= 1'b0;
      ovl_q   <= '0;
      sp_q    <= '0;
    end else if (accept) begin
      instr_q <= instr_i;
      feat_q  <= feat_en_i;
      big_q   <= big_endian_i;
      priv_q  <= (el_i != 2'd0);
      ovl_q   <= ovl_mode_i;
      sp_q    <= sp_i;
    end
  end

  pswap_decode #(.IW(IW)) u_dec (
    .instr_i (instr_q),
    .feat_i  (feat_q),
    .ovl_i   (ovl_q),
    .rt_o    (rt),
    .rt2_o   (rt2),
    .rn_o    (rn),
    .acq_o   (acq),
    .rel_o   (rel),
    .res_o   (dec_res),
    .fill_o  (fill_d)
  );

  assign sp_bad = (rn == IDX_SP) && (sp_q[AL_W-1:0] != '0);

  pswap_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .dec_res_i   (dec_res),
    .sp_bad_i    (sp_bad),
    .mem_ready_i (mem_ready_i),
    .rsp_valid_i (mem_rsp_valid_i),
    .state_o     (state),
    .res_o       (res),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  pswap_endian #(.W(XW)) u_end (
    .big_i   (big_q),
    .v1_i    (rf_rdata0_i),
    .v2_i    (rf_rdata1_i),
    .store_o (store_d),
    .load_i  (load_q),
    .r1_o    (wb1),
    .r2_o    (wb2)
  );

  assign rf_raddr0_o = rt;
  assign rf_raddr1_o = rt2;
  assign rf_raddr2_o = rn;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      store_q <= '0;
      fill_q  <= 1'b0;
      load_q  <= '0;
    end else begin
      if (state == ST_DECODE) begin
        addr_q  <= (rn == IDX_SP) ? sp_q : rf_rdata2_i;
        store_q <= store_d;
        fill_q  <= fill_d;
      end
      if (state == ST_WAIT && mem_rsp_valid_i) load_q <= mem_rdata_i;
    end
  end

  assign mem_req_o   = (state == ST_REQ);
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = store_q;
  assign mem_acq_o   = acq;
  assign mem_rel_o   = rel;
  assign mem_priv_o  = priv_q;
  assign mem_tag_o   = (rn != IDX_SP);

  assign rf_we_o     = (state == ST_WB);
  assign rf_waddr0_o = rt;
  assign rf_waddr1_o = rt2;
  assign rf_wdata0_o = fill_q ? FILL_WORD[XW-1:0] : wb1;
  assign rf_wdata1_o = fill_q ? FILL_WORD[XW-1:0] : wb2;

  assign undef_o       = done_o && (res == RES_UNDEF);
  assign nop_o         = done_o && (res == RES_NOP);
  assign align_fault_o = done_o && (res == RES_ALIGN);

  AST_REQ_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_wdata_o))); // R9
  AST_WB_AFTER_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> $past(mem_rsp_valid_i)); // R8
  AST_REQ_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o || rf_we_o) |-> busy_o); // R10
  AST_IDX31_UNDEF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_DECODE && (rt == IDX_SP || rt2 == IDX_SP)) |=> undef_o); // R3
  AST_MISALIGN_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_DECODE && dec_res == RES_OK && sp_bad) |=> (align_fault_o && !mem_req_o)); // R6
endmodule

// File: tb/pair_swap_unit_test.sv
module pair_swap_unit_test;
  localparam logic [63:0] FILL = 64'hA5A5_5A5A_A5A5_5A5A;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [31:0]  instr_i = '0;
  logic         feat_en_i = 1'b0, big_endian_i = 1'b0;
  logic [1:0]   el_i = '0, ovl_mode_i = '0;
  logic [63:0]  sp_i = '0;
  logic [4:0]   rf_raddr0_o, rf_raddr1_o, rf_raddr2_o, rf_waddr0_o, rf_waddr1_o;
  logic [63:0]  rf_rdata0_i, rf_rdata1_i, rf_rdata2_i, rf_wdata0_o, rf_wdata1_o;
  logic         rf_we_o, mem_req_o, mem_ready_i = 1'b0;
  logic [63:0]  mem_addr_o;
  logic [127:0] mem_wdata_o, mem_rdata_i = '0;
  logic         mem_acq_o, mem_rel_o, mem_priv_o, mem_tag_o, mem_rsp_valid_i = 1'b0;
  logic         busy_o, done_o, undef_o, nop_o, align_fault_o;

  pair_swap_unit uut (.*);

  always #5 clk_i = ~clk_i;

  logic [63:0]  rf_m [32];
  logic [127:0] mem_m [16];
  assign rf_rdata0_i = rf_m[rf_raddr0_o];
  assign rf_rdata1_i = rf_m[rf_raddr1_o];
  assign rf_rdata2_i = rf_m[rf_raddr2_o];

  int total = 0, bad = 0;
  int req_cnt = 0, we_cnt = 0;
  logic [63:0]  req_addr;
  logic [127:0] req_wdata;
  logic [3:0]   req_flags;
  logic         pend = 1'b0;
  int           pend_cnt = 0;
  logic [127:0] pend_data;

  // memory and register-file models, driven away from the active edge
  always @(negedge clk_i) begin
    mem_ready_i = 1'b0;
    mem_rsp_valid_i = 1'b0;
    if (rf_we_o) begin
      we_cnt++;
      rf_m[rf_waddr0_o] = rf_wdata0_o;
      rf_m[rf_waddr1_o] = rf_wdata1_o;
    end
    if (pend) begin
      if (pend_cnt == 0) begin
        mem_rsp_valid_i = 1'b1;
        mem_rdata_i = pend_data;
        pend = 1'b0;
      end else pend_cnt--;
    end else if (mem_req_o && ($urandom % 3 != 0)) begin
      mem_ready_i = 1'b1;
      req_cnt++;
      req_addr  = mem_addr_o;
      req_wdata = mem_wdata_o;
      req_flags = {mem_acq_o, mem_rel_o, mem_priv_o, mem_tag_o};
      pend_data = mem_m[mem_addr_o[7:4]];
      mem_m[mem_addr_o[7:4]] = mem_wdata_o;
      pend = 1'b1;
      pend_cnt = $urandom % 3;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input bit a, input bit r, input logic [4:0] t2, input logic [4:0] n, input logic [4:0] t);
    return {8'b0001_1001, a, r, 1'b1, t2, 6'b10_0000, n, t};
  endfunction

  // 0 ok, 1 undef, 2 nop, 3 align
  function automatic int exp_res(input logic [31:0] w, input bit feat, input logic [1:0] ovl, input logic [63:0] sp);
    bit legal;
    legal = w[31:24] == 8'h19 && w[21] == 1'b1 && w[15:10] == 6'h20;
    if (!feat || !legal) return 1;
    if (w[4:0] == 5'd31 || w[20:16] == 5'd31) return 1;
    if (w[4:0] == w[20:16]) begin
      if (ovl == 2'd1) return 2;
      if (ovl != 2'd2) return 1;
    end
    if (w[9:5] == 5'd31 && sp[3:0] != 4'd0) return 3;
    return 0;
  endfunction

  task automatic do_op(input logic [31:0] w, input bit feat, input bit be, input logic [1:0] el,
                       input logic [1:0] ovl, input logic [63:0] sp);
    logic [63:0]  rs [32];
    logic [127:0] ms [16];
    logic [4:0]   t, t2, n;
    logic [63:0]  addr;
    logic [127:0] store, old;
    int           er, wd;
    bit           same;
    string        rtag;
    t = w[4:0]; t2 = w[20:16]; n = w[9:5];
    for (int i = 0; i < 32; i++) rs[i] = rf_m[i];
    for (int i = 0; i < 16; i++) ms[i] = mem_m[i];
    er = exp_res(w, feat, ovl, sp);
    addr  = (n == 5'd31) ? sp : rs[n];
    store = be ? {rs[t], rs[t2]} : {rs[t2], rs[t]};
    old   = ms[addr[7:4]];
    rtag = (w[31:24] != 8'h19 || !w[21] || w[15:10] != 6'h20) ? "R1" : !feat ? "R2" :
           (t == 5'd31 || t2 == 5'd31) ? "R3" : (t == t2) ? "R4" : (er == 3) ? "R6" : "R8";
    req_cnt = 0; we_cnt = 0;
    @(negedge clk_i);
    instr_i = w; feat_en_i = feat; big_endian_i = be; el_i = el; ovl_mode_i = ovl; sp_i = sp;
    start_i = 1'b1;
    @(negedge clk_i);
    chk(busy_o === 1'b1, "R10 busy after accept", {127'd0, busy_o}, 128'd1);
    instr_i = ~w; feat_en_i = ~feat; sp_i = ~sp;   // must be ignored
    @(negedge clk_i);
    start_i = 1'b0;
    wd = 0;
    while (!done_o && wd < 200) begin @(negedge clk_i); wd++; end
    chk(wd < 200, "R10 done timeout", wd, 0);
    chk({undef_o, nop_o, align_fault_o} == {er == 1, er == 2, er == 3}, {rtag, " outcome flags"},
        {undef_o, nop_o, align_fault_o}, {er == 1, er == 2, er == 3});
    @(negedge clk_i);
    chk(!busy_o && !done_o, "R10 idle after done", {busy_o, done_o}, 0);
    chk(req_cnt == (er == 0 ? 1 : 0), {rtag, " request count"}, req_cnt, er == 0);
    chk(we_cnt == (er == 0 ? 1 : 0), {rtag, " write count"}, we_cnt, er == 0);
    if (er == 0) begin
      chk(req_addr == addr, "R5 address", req_addr, addr);
      chk(req_flags[0] == (n != 5'd31), "R5 tag flag", req_flags[0], n != 5'd31);
      chk(req_flags[3:1] == {w[23], w[22], el != 2'd0}, "R9 acq/rel/priv", req_flags[3:1], {w[23], w[22], el != 2'd0});
      chk(req_wdata == store, "R7 store value", req_wdata, store);
      chk(mem_m[addr[7:4]] == store, "R7 memory content", mem_m[addr[7:4]], store);
      if (t == t2) begin
        chk(rf_m[t] == FILL, "R4 filler written", rf_m[t], FILL);
      end else begin
        chk(rf_m[t]  == (be ? old[127:64] : old[63:0]), "R8 first reg", rf_m[t], be ? old[127:64] : old[63:0]);
        chk(rf_m[t2] == (be ? old[63:0] : old[127:64]), "R8 second reg", rf_m[t2], be ? old[63:0] : old[127:64]);
      end
    end else begin
      same = 1'b1;
      for (int i = 0; i < 32; i++) if (rf_m[i] != rs[i]) same = 1'b0;
      for (int i = 0; i < 16; i++) if (mem_m[i] != ms[i]) same = 1'b0;
      chk(same, {rtag, " state untouched"}, same, 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    bad++;
    $display("FAIL watchdog expired act=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 32; i++) rf_m[i] = {$urandom, $urandom};
    for (int i = 0; i < 16; i++) mem_m[i] = {$urandom, $urandom, $urandom, $urandom};
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o && !mem_req_o && !rf_we_o && !undef_o, "R10 reset state",
        {busy_o, done_o, mem_req_o, rf_we_o, undef_o}, 0);
    rst_ni = 1'b1;
    // directed cases
    do_op(enc(1, 0, 5'd2, 5'd7, 5'd1), 1, 0, 2'd0, 2'd0, 64'h100);          // R8 little-endian
    do_op(enc(0, 1, 5'd4, 5'd8, 5'd3), 1, 1, 2'd1, 2'd0, 64'h100);          // R7 big-endian
    do_op(enc(1, 1, 5'd2, 5'd31, 5'd5), 1, 1, 2'd2, 2'd0, 64'h40);          // R5 sp aligned
    do_op(enc(0, 0, 5'd2, 5'd31, 5'd5), 1, 0, 2'd0, 2'd0, 64'h48);          // R6 misaligned
    do_op(enc(0, 0, 5'd2, 5'd31, 5'd5), 0, 0, 2'd0, 2'd0, 64'h48);          // R2 beats R6
    do_op(enc(0, 0, 5'd2, 5'd6, 5'd31), 1, 0, 2'd0, 2'd0, 64'h0);           // R3 first
    do_op(enc(0, 0, 5'd31, 5'd6, 5'd2), 1, 0, 2'd0, 2'd0, 64'h0);           // R3 second
    do_op(enc(0, 0, 5'd2, 5'd6, 5'd1) ^ 32'h0020_0000, 1, 0, 2'd0, 2'd0, 0); // R1 bit 21
    do_op(enc(0, 0, 5'd2, 5'd6, 5'd1) ^ 32'h0000_0400, 1, 0, 2'd0, 2'd0, 0); // R1 bits 15:10
    for (int m = 0; m < 4; m++) do_op(enc(0, 1, 5'd9, 5'd6, 5'd9), 1, m[0], 2'd1, m[1:0], 64'h0); // R4
    do_op(enc(0, 0, 5'd9, 5'd31, 5'd9), 1, 0, 2'd0, 2'd1, 64'h4);           // R4 nop beats R6
    do_op(enc(0, 0, 5'd9, 5'd31, 5'd9), 1, 1, 2'd0, 2'd2, 64'h30);          // R4 fill via sp
    // random mix
    for (int k = 0; k < 400; k++) begin
      logic [31:0] w;
      logic [4:0]  t, t2;
      t  = ($urandom % 8 == 0) ? 5'd31 : 5'($urandom % 31);
      t2 = ($urandom % 6 == 0) ? t : ($urandom % 8 == 0) ? 5'd31 : 5'($urandom % 31);
      w = enc($urandom % 2 == 1, $urandom % 2 == 1, t2, ($urandom % 4 == 0) ? 5'd31 : 5'($urandom), t);
      if ($urandom % 10 == 0) w = w ^ (32'd1 << ($urandom % 32));
      do_op(w, $urandom % 10 != 0, $urandom % 2 == 1, 2'($urandom), 2'($urandom),
            {$urandom, $urandom} & (($urandom % 4 == 0) ? 64'hFF : 64'hF0));
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule